// File: doc/BRIEF.md
# Time-Triggered Task Dispatcher

This block starts tasks at instants that were fixed before operation. Software or a boot sequencer fills a small schedule, made of up to sixteen pairs of a time offset and a task number, together with the length of one schedule round. Once enabled, a free-running timebase counts through the round. Whenever it equals the offset of the next pending schedule entry, the named task becomes the running task. No priority comparison is made at run time, so every activation shows up on the outputs after the same fixed delay.

There is no waiting-to-run state. A task that is displaced by a new activation is parked as Preempted on a four-deep last-in-first-out stack. When the running task signals completion, the most recently parked task resumes. An activation that cannot be honoured is dropped and raises a sticky overrun flag. This happens when the task is already active, or when the stack has no room for the task being displaced. Clearing the enable stops the schedule and returns every task to Suspended. The schedule can be rewritten only while the block is disabled.

Top module: `tt_dispatcher`

## Requirements
- R1: While `rst_n` is low or `enable` is low, every task reads Suspended, `run_valid`, `preempt` and `overrun` are 0, the timebase is held at 0 and the schedule pointer at the first entry.
- R2: `task_state` carries two bits per task at bits [2i+1:2i] for task i: 2'b00 Suspended, 2'b01 Running, 2'b10 Preempted. At most one task reads Running, and `run_valid` is 1 exactly when one does. `run_task` is meaningful only while `run_valid` is 1.
- R3: While enabled, the timebase steps by one per clock from 0 to `round_len`-1 and then returns to 0. On that return the schedule pointer goes back to entry 0. Entries at index `entry_count` and above never fire. An entry fires when its offset equals the timebase, and the pointer then moves to the next entry, so entries must be stored with ascending offsets.
- R4: When an entry fires and is accepted, its task reads Running, with `run_task` equal to it, on the clock edge that ends the cycle in which the timebase matched. This one-cycle delay does not depend on the other tasks.
- R5: An accepted activation while another task runs without completing moves that task to Preempted and pushes it. `preempt` is 1 for exactly the output cycle in which the switch appears.
- R6: `term_pulse` while a task runs returns it to Suspended. The most recently preempted task resumes as Running in the same output cycle. If none is parked, `run_valid` drops to 0. `term_pulse` with no task running has no effect.
- R7: When `term_pulse` and an accepted activation meet in one cycle, the old task becomes Suspended and the new one Running. No task is pushed and `preempt` stays 0.
- R8: An activation of a task that is Preempted, or Running without completing in that cycle, is dropped. `overrun` then goes to 1 and stays 1 until the block is disabled.
- R9: An activation that would have to push a fifth task onto the full stack is dropped, and `overrun` goes to 1.
- R10: Writes through `cfg_we` and `cfg_len_we` take effect only while `enable` is 0. Writes made while enabled leave the schedule unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the schedule when 1; idles and allows configuration when 0 |
| cfg_we | input | 1 | Write one schedule entry |
| cfg_addr | input | 4 | Schedule entry index |
| cfg_offset | input | 16 | Activation time of the entry within the round |
| cfg_task | input | 3 | Task started by the entry |
| cfg_len_we | input | 1 | Write round length and entry count |
| cfg_len | input | 16 | Round length in clocks |
| cfg_count | input | 5 | Number of valid entries (0 to 16) |
| term_pulse | input | 1 | Completion strobe from the running task |
| run_valid | output | 1 | A task is running |
| run_task | output | 3 | Index of the running task |
| task_state | output | 16 | Two-bit state per task |
| preempt | output | 1 | One-cycle strobe when a running task is displaced |
| overrun | output | 1 | Sticky: an activation was dropped |

## Verification
The stimulus first stacks four preempted tasks, then fires a fifth activation that finds the stack full. A design that pushed anyway would lose or corrupt a parked task, and one that ignored the fullness would not raise `overrun`. Completion strobes are placed in the same cycle as activations. A design that handled these as a completion followed by a preemption would pulse `preempt` and leave a stale entry on the stack. Activations of a task that is Running, and of one that is Preempted, check that duplicates are dropped rather than given a second copy on the stack. A schedule write while enabled, and an entry written beyond the valid count, would each start a task at a visibly wrong time if they were honoured.

// File: rtl/tt_disp_pkg.sv
package tt_disp_pkg;
  typedef enum logic [1:0] {
    TS_SUSP = 2'b00,
    TS_RUN  = 2'b01,
    TS_PRE  = 2'b10
  } task_state_e;
endpackage

// File: rtl/tt_sched_table.sv
module tt_sched_table #(
  parameter int TIME_W = 16,
  parameter int TASK_W = 3,
  parameter int DEPTH  = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [TIME_W-1:0] cfg_offset,
  input  logic [TASK_W-1:0] cfg_task,
  input  logic              cfg_len_we,
  input  logic [TIME_W-1:0] cfg_len,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              fire,
  output logic [TASK_W-1:0] fire_task
);
  logic [TIME_W-1:0] off_q [DEPTH];
  logic [TASK_W-1:0] tid_q [DEPTH];
  logic [TIME_W-1:0] len_q, tb_q, tb_d;
  logic [CNT_W-1:0]  cnt_q, idx_q, idx_d;
  logic              round_end;
  logic              cfg_ok;

  assign cfg_ok = !enable;

  // schedule storage: no reset, only entries below the count are read
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (cfg_ok && cfg_we && (cfg_addr == AW'(g))) begin
        off_q[g] <= cfg_offset;
        tid_q[g] <= cfg_task;
      end
    end
  end

  assign fire      = enable && (idx_q < cnt_q) && (off_q[idx_q[AW-1:0]] == tb_q);
  assign fire_task = tid_q[idx_q[AW-1:0]];
  assign round_end = (tb_q == len_q - TIME_W'(1));

  always_comb begin
    tb_d  = tb_q;
    idx_d = idx_q;
    if (!enable) begin
      tb_d  = '0;
      idx_d = '0;
    end else if (round_end) begin
      tb_d  = '0;
      idx_d = '0;
    end else begin
      tb_d = tb_q + TIME_W'(1);
      if (fire) idx_d = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
      tb_q  <= '0;
      idx_q <= '0;
    end else begin
      if (cfg_ok && cfg_len_we) begin
        len_q <= cfg_len;
        cnt_q <= cfg_count;
      end
      tb_q  <= tb_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/tt_preempt_lifo.sv
module tt_preempt_lifo #(
  parameter int W     = 3,
  parameter int DEPTH = 4,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] top_ptr;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign top_ptr = PW'(cnt_q - CW'(1));
  assign top     = mem_q[top_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && !flush && (cnt_q == CW'(g))) mem_q[g] <= din;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (flush)               cnt_d = '0;
    else if (push && !full)  cnt_d = cnt_q + CW'(1);
    else if (pop && !empty)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tt_dispatcher.sv
module tt_dispatcher
  import tt_disp_pkg::*;
#(
  parameter int NUM_TASKS   = 8,
  parameter int TASK_W      = $clog2(NUM_TASKS),
  parameter int TIME_W      = 16,
  parameter int TBL_DEPTH   = 16,
  parameter int TBL_AW      = $clog2(TBL_DEPTH),
  parameter int CNT_W       = $clog2(TBL_DEPTH + 1),
  parameter int STACK_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   cfg_we,
  input  logic [TBL_AW-1:0]      cfg_addr,
  input  logic [TIME_W-1:0]      cfg_offset,
  input  logic [TASK_W-1:0]      cfg_task,
  input  logic                   cfg_len_we,
  input  logic [TIME_W-1:0]      cfg_len,
  input  logic [CNT_W-1:0]       cfg_count,
  input  logic                   term_pulse,
  output logic                   run_valid,
  output logic [TASK_W-1:0]      run_task,
  output logic [2*NUM_TASKS-1:0] task_state,
  output logic                   preempt,
  output logic                   overrun
);
  logic              fire;
  logic [TASK_W-1:0] fire_task;
  logic [TASK_W-1:0] stk_top;
  logic              stk_empty, stk_full, stk_push, stk_pop;

  task_state_e       st_q [NUM_TASKS];
  task_state_e       st_d [NUM_TASKS];
  logic              rv_q, rv_d, pre_q, pre_d, ovr_q, ovr_d;
  logic [TASK_W-1:0] rt_q, rt_d;
  logic              clash, stk_block, accept, ovr_hit, done;

  tt_sched_table #(
    .TIME_W(TIME_W), .TASK_W(TASK_W), .DEPTH(TBL_DEPTH)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_offset(cfg_offset), .cfg_task(cfg_task),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len), .cfg_count(cfg_count),
    .fire(fire), .fire_task(fire_task)
  );

  tt_preempt_lifo #(
    .W(TASK_W), .DEPTH(STACK_DEPTH)
  ) u_lifo (
    .clk(clk), .rst_n(rst_n), .flush(!enable), .push(stk_push), .pop(stk_pop),
    .din(rt_q), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  // admission of the activation offered by the schedule this cycle
  assign done      = term_pulse && rv_q;
  assign clash     = fire && (((st_q[fire_task] == TS_RUN) && !term_pulse) ||
                              (st_q[fire_task] == TS_PRE));
  assign stk_block = fire && !clash && rv_q && !term_pulse && stk_full;
  assign accept    = fire && !clash && !stk_block;
  assign ovr_hit   = clash || stk_block;

  always_comb begin
    st_d     = st_q;
    rv_d     = rv_q;
    rt_d     = rt_q;
    pre_d    = 1'b0;
    ovr_d    = ovr_q | ovr_hit;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    if (!enable) begin
      for (int i = 0; i < NUM_TASKS; i++) st_d[i] = TS_SUSP;
      rv_d  = 1'b0;
      rt_d  = '0;
      ovr_d = 1'b0;
    end else if (accept) begin
      if (rv_q) begin
        if (term_pulse) begin
          st_d[rt_q] = TS_SUSP;
        end else begin
          st_d[rt_q] = TS_PRE;
          stk_push   = 1'b1;
          pre_d      = 1'b1;
        end
      end
      st_d[fire_task] = TS_RUN;
      rv_d = 1'b1;
      rt_d = fire_task;
    end else if (done) begin
      st_d[rt_q] = TS_SUSP;
      if (!stk_empty) begin
        stk_pop       = 1'b1;
        st_d[stk_top] = TS_RUN;
        rt_d          = stk_top;
      end else begin
        rv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TASKS; i++) st_q[i] <= TS_SUSP;
      rv_q  <= 1'b0;
      rt_q  <= '0;
      pre_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rv_q  <= rv_d;
      rt_q  <= rt_d;
      pre_q <= pre_d;
      ovr_q <= ovr_d;
    end
  end

  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_state_out
    assign task_state[2*g+1:2*g] = st_q[g];
  end

  assign run_valid = rv_q;
  assign run_task  = rt_q;
  assign preempt   = pre_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/tt_dispatcher_chk.sv
module tt_dispatcher_chk #(
  parameter int NUM_TASKS = 8,
  parameter int TASK_W    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic                   term_pulse,
  input logic                   fire,
  input logic [TASK_W-1:0]      fire_task,
  input logic                   ovr_hit,
  input logic                   stk_empty,
  input logic                   run_valid,
  input logic [TASK_W-1:0]      run_task,
  input logic [2*NUM_TASKS-1:0] task_state,
  input logic                   preempt,
  input logic                   overrun
);
  logic [NUM_TASKS-1:0] running;
  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_run
    assign running[g] = (task_state[2*g+1:2*g] == 2'b01);
  end

  a_r2_single_runner: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(running) <= 1) && (run_valid == (|running)));

  a_r4_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fire && !ovr_hit) |=> (run_valid && (run_task == $past(fire_task))));

  a_r5_preempt_switch: assert property (@(posedge clk) disable iff (!rst_n)
    preempt |-> (run_valid && $past(run_valid) && (run_task != $past(run_task))));

  a_r6_term_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && term_pulse && run_valid && stk_empty && !fire) |=> !run_valid);

  a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ovr_hit) |=> overrun);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && overrun) |=> overrun);

  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!run_valid && !overrun && !preempt && (task_state == '0)));
endmodule

bind tt_dispatcher tt_dispatcher_chk #(
  .NUM_TASKS(NUM_TASKS), .TASK_W(TASK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .term_pulse(term_pulse),
  .fire(fire), .fire_task(fire_task), .ovr_hit(ovr_hit), .stk_empty(stk_empty),
  .run_valid(run_valid), .run_task(run_task), .task_state(task_state),
  .preempt(preempt), .overrun(overrun)
);

// File: tb/tt_dispatcher_bench.sv
module tt_dispatcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_offset = '0;
  logic [2:0]  cfg_task = '0;
  logic        cfg_len_we = 1'b0;
  logic [15:0] cfg_len = '0;
  logic [4:0]  cfg_count = '0;
  logic        term_pulse = 1'b0;
  logic        run_valid;
  logic [2:0]  run_task;
  logic [15:0] task_state;
  logic        preempt;
  logic        overrun;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  always #10ns clk = ~clk;

  tt_dispatcher u_tt_dispatcher (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_offset(cfg_offset), .cfg_task(cfg_task),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len), .cfg_count(cfg_count),
    .term_pulse(term_pulse), .run_valid(run_valid), .run_task(run_task),
    .task_state(task_state), .preempt(preempt), .overrun(overrun)
  );

  // behavioural reference: 0 Suspended, 1 Running, 2 Preempted
  int m_off [16];
  int m_tid [16];
  int m_len = 0, m_cnt = 0, m_tb = 0, m_idx = 0;
  int m_state [8];
  int m_stack [$];
  bit m_rv = 0, m_pre = 0, m_ovr = 0;
  int m_rt = 0;

  always @(posedge clk or negedge rst_n) begin
    bit fire, took;
    int ft;
    if (!rst_n) begin
      m_len = 0; m_cnt = 0; m_tb = 0; m_idx = 0;
      foreach (m_state[i]) m_state[i] = 0;
      m_stack.delete();
      m_rv = 0; m_rt = 0; m_pre = 0; m_ovr = 0;
    end else if (!enable) begin
      if (cfg_we) begin m_off[cfg_addr] = cfg_offset; m_tid[cfg_addr] = cfg_task; end
      if (cfg_len_we) begin m_len = cfg_len; m_cnt = cfg_count; end
      m_tb = 0; m_idx = 0;
      foreach (m_state[i]) m_state[i] = 0;
      m_stack.delete();
      m_rv = 0; m_pre = 0; m_ovr = 0;
    end else begin
      fire = (m_idx < m_cnt) && (m_off[m_idx] == m_tb);
      ft   = (m_idx < 16) ? m_tid[m_idx] : 0;
      took = 0;
      m_pre = 0;
      if (fire) begin
        if ((m_state[ft] == 1 && !term_pulse) || m_state[ft] == 2 ||
            (m_rv && !term_pulse && m_stack.size() == 4)) begin
          m_ovr = 1;
        end else begin
          took = 1;
          if (m_rv) begin
            if (term_pulse) m_state[m_rt] = 0;
            else begin m_state[m_rt] = 2; m_stack.push_back(m_rt); m_pre = 1; end
          end
          m_state[ft] = 1; m_rv = 1; m_rt = ft;
        end
      end
      if (!took && term_pulse && m_rv) begin
        m_state[m_rt] = 0;
        if (m_stack.size() > 0) begin m_rt = m_stack.pop_back(); m_state[m_rt] = 1; end
        else m_rv = 0;
      end
      if (m_tb == m_len - 1) begin m_tb = 0; m_idx = 0; end
      else begin m_tb++; if (fire) m_idx++; end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] ev;
    for (int i = 0; i < 8; i++) ev[2*i +: 2] = 2'(m_state[i]);
    check({tag, " R2"}, "run_valid", int'(run_valid), int'(m_rv));
    if (m_rv) check({tag, " R4"}, "run_task", int'(run_task), m_rt);
    check({tag, " R2"}, "task_state", int'(task_state), int'(ev));
    check({tag, " R5"}, "preempt", int'(preempt), int'(m_pre));
    check({tag, " R8"}, "overrun", int'(overrun), int'(m_ovr));
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic put_entry(int a, int off, int t);
    cfg_we = 1; cfg_addr = 4'(a); cfg_offset = 16'(off); cfg_task = 3'(t);
    step();
    cfg_we = 0;
  endtask

  task automatic put_round(int len, int cnt);
    cfg_len_we = 1; cfg_len = 16'(len); cfg_count = 5'(cnt);
    step();
    cfg_len_we = 0;
  endtask

  function automatic bit term_first(int tb);
    return tb == 9 || tb == 10 || (tb >= 16 && tb <= 20) || tb == 24 || tb == 25;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    step();
    check("R1", "reset run_valid", int'(run_valid), 0);
    check("R1", "reset task_state", int'(task_state), 0);
    check("R1", "reset overrun", int'(overrun), 0);
    rst_n = 1'b1;
    step();

    // first schedule: nested preemption, full stack, duplicates, coincidence
    tag = "R3 R9";
    put_entry(0, 1, 0);  put_entry(1, 3, 1);  put_entry(2, 4, 2);
    put_entry(3, 5, 3);  put_entry(4, 6, 4);  put_entry(5, 7, 5);
    put_entry(6, 10, 4); put_entry(7, 12, 3); put_entry(8, 14, 2);
    put_entry(9, 20, 6); put_entry(10, 22, 6);
    put_round(28, 11);
    enable = 1;
    for (int c = 0; c < 3 * 28; c++) begin
      step();
      tag = "R3 R6 R7 R9";
      term_pulse = term_first(m_tb);
      // R10: writes while enabled must be ignored
      cfg_we = (c == 30);
      cfg_addr = 4'd0; cfg_offset = 16'd2; cfg_task = 3'd7;
      cfg_len_we = (c == 31);
      cfg_len = 16'd3; cfg_count = 5'd1;
    end
    tag = "R10";
    step();
    cfg_we = 0; cfg_len_we = 0; term_pulse = 0;

    // R1: disabling clears runtime state
    enable = 0;
    tag = "R1";
    step();
    step();
    check("R1", "disabled run_valid", int'(run_valid), 0);
    check("R1", "disabled overrun", int'(overrun), 0);

    // second schedule: short round, entry past the count must stay silent (R3)
    put_entry(0, 0, 1);
    put_entry(1, 2, 2);
    put_entry(2, 4, 5);
    put_round(5, 2);
    enable = 1;
    tag = "R3 R4 R7";
    for (int c = 0; c < 30; c++) begin
      step();
      term_pulse = (m_tb == 2) || (m_tb == 3) || (m_tb == 4 && c > 15);
    end
    term_pulse = 0;
    step();
    finish_run();
  end
endmodule